// File: doc/BRIEF.md
# Two-Byte Command Register I2C Slave

This block is an I2C slave port that owns a pair of command bytes. It samples the bus lines SCL and SDA with a system clock that runs much faster than the bus. Both lines pass through a stable-count glitch filter. The block then finds START, repeated START and STOP events on the filtered lines. It drives SDA only through an active-high pull-down enable, which the pad turns into an open-drain output.

A write transaction carries the slave's write address and then two data bytes. The slave acknowledges all three, and the two data bytes go into a staging pair. The command outputs take the staged bytes only when the master closes the transaction with STOP. In that same cycle a one-cycle commit strobe marks the update.

A read transaction carries the read address. The slave acknowledges it and then shifts out one status byte, which is taken from an input port. The slave releases SDA during the acknowledge clock that follows, and the master's reply has no effect.

Top module: `cmd_pair_i2c_slave`

## Requirements
- R1: After reset, `cmdA` and `cmdB` are 0x00, `commitPulse` is low and `sdaPullDn` is low (SDA released).
- R2: A byte whose upper seven bits equal the parameter `DEV_ADDR` and whose LSB is 0 (write) gets an ACK. The slave holds `sdaPullDn` high through the whole high phase of the ninth SCL clock.
- R3: In a write, the first two data bytes are received MSB first and each is ACKed. Until a STOP arrives, `cmdA` and `cmdB` keep their previous values.
- R4: A STOP that follows two ACKed data bytes copies byte A to `cmdA` and byte B to `cmdB`. `commitPulse` is high for exactly one system-clock cycle, and that is the cycle in which the new values first appear.
- R5: Data bytes after the second one in a write are not ACKed and are discarded. A later STOP still commits the first two bytes.
- R6: A STOP that comes before two data bytes have been received leaves `cmdA` and `cmdB` unchanged and gives no `commitPulse`.
- R7: An address byte whose upper seven bits differ from `DEV_ADDR` gets no ACK. `sdaPullDn` then stays low until the next START or STOP, and the STOP does not update the outputs. The cycle after any STOP, `sdaPullDn` is low.
- R8: An address byte that matches `DEV_ADDR` with LSB 1 (read) gets an ACK. The slave then shifts out `statusIn` MSB first and releases SDA during the ninth clock. The master's ACK or NACK changes nothing, and a read never commits.
- R9: A repeated START restarts address reception. The staged bytes of a write it interrupts are abandoned, so a later STOP does not commit them.
- R10: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system-clock cycles is ignored. It is not counted as a clock edge, START or STOP.
- R11: `sdaPullDn` changes only while the filtered SCL is low, or in the cycle right after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| statusIn | input | 8 | Byte returned on a read transaction |
| sdaPullDn | output | 1 | High to pull SDA low (open-drain enable) |
| cmdA | output | 8 | Committed command byte A |
| cmdB | output | 8 | Committed command byte B |
| commitPulse | output | 1 | One-cycle strobe when cmdA/cmdB take new values |

## Verification
The assertions check, on every cycle:
- that the command outputs change only together with a single-cycle commit strobe;
- that the strobe always follows a detected STOP;
- that the SDA driver moves only while SCL is low;
- that the acknowledge and transmit drivers never overlap.

Only the bench's transactions can show the rest:
- which bytes are acknowledged;
- whether the status byte comes out in the right bit order;
- whether short, long, misaddressed and interrupted writes commit the right bytes or none;
- whether filter-length pulses on either line are rejected.

// File: rtl/i2c_cmd_pkg.sv
package i2cCmdPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int BIT_CNT_W = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WDATA,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic sampleBit;
    logic loadTx;
    logic shiftTx;
    logic stageA;
    logic stageB;
    logic commit;
  } dpStrobes_t;
endpackage

// File: rtl/i2c_glitch_filter.sv
module i2cGlitchFilter #(
  parameter int STABLE_CNT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(STABLE_CNT + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= 2'b11;
      runCnt   <= '0;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != cleanOut) begin
        if (runCnt == CW'(STABLE_CNT - 1)) begin
          cleanOut <= syncQ[1];
          runCnt   <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_ctl.sv
module i2cCmdCtl
  import i2cCmdPkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [BYTE_W-1:0] rxByte,
  output dpStrobes_t        strb,
  output logic              ackDrv,
  output logic              txDrv,
  output logic              startDet,
  output logic              stopDet
);
  busState_e            state;
  logic [BIT_CNT_W-1:0] bitCnt;
  logic [1:0]           byteCnt;
  logic                 isRead;
  logic                 sclQ, sdaQ;
  logic                 sclRise, sclFall, byteDone, addrHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startDet = sclF & sclQ & sdaQ & ~sdaF;
  assign stopDet  = sclF & sclQ & ~sdaQ & sdaF;
  assign byteDone = (bitCnt == BIT_CNT_W'(BYTE_W));
  assign addrHit  = (rxByte[BYTE_W-1:1] == DEV_ADDR);

  always_comb begin
    strb           = '0;
    strb.sampleBit = (state == ST_ADDR || state == ST_WDATA) && sclRise && !byteDone;
    strb.stageA    = (state == ST_WDATA) && sclFall && byteDone && (byteCnt == 2'd0);
    strb.stageB    = (state == ST_WDATA) && sclFall && byteDone && (byteCnt == 2'd1);
    strb.loadTx    = (state == ST_ACK) && sclFall && isRead;
    strb.shiftTx   = (state == ST_RDATA) && sclFall && !byteDone;
    strb.commit    = stopDet && (byteCnt == 2'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      ackDrv  <= 1'b0;
      txDrv   <= 1'b0;
    end else if (startDet) begin
      state   <= ST_ADDR;
      bitCnt  <= '0;
      byteCnt <= '0;
      isRead  <= 1'b0;
      ackDrv  <= 1'b0;
      txDrv   <= 1'b0;
    end else if (stopDet) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      byteCnt <= '0;
      ackDrv  <= 1'b0;
      txDrv   <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WDATA: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                ackDrv <= 1'b1;
                isRead <= rxByte[0];
                state  <= ST_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else if (byteCnt < 2'd2) begin
              ackDrv  <= 1'b1;
              byteCnt <= byteCnt + 1'b1;
              state   <= ST_ACK;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            ackDrv <= 1'b0;
            if (isRead) begin
              txDrv <= 1'b1;
              state <= ST_RDATA;
            end else begin
              state <= ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (sclRise && !byteDone) bitCnt <= bitCnt + 1'b1;
          if (sclFall && byteDone) begin
            txDrv  <= 1'b0;
            bitCnt <= '0;
            state  <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclFall) state <= ST_IGNORE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_data.sv
module i2cCmdData
  import i2cCmdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txMsb,
  output logic [BYTE_W-1:0] cmdA,
  output logic [BYTE_W-1:0] cmdB,
  output logic              commitPulse
);
  logic [BYTE_W-1:0] txShift, stageA, stageB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte      <= '0;
      txShift     <= '0;
      stageA      <= '0;
      stageB      <= '0;
      cmdA        <= '0;
      cmdB        <= '0;
      commitPulse <= 1'b0;
    end else begin
      if (strb.sampleBit) rxByte <= {rxByte[BYTE_W-2:0], sdaBit};
      if (strb.loadTx)       txShift <= statusByte;
      else if (strb.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (strb.stageA) stageA <= rxByte;
      if (strb.stageB) stageB <= rxByte;
      commitPulse <= strb.commit;
      if (strb.commit) begin
        cmdA <= stageA;
        cmdB <= stageB;
      end
    end
  end

  assign txMsb = txShift[BYTE_W-1];
endmodule

// File: rtl/cmd_pair_i2c_slave.sv
module cmd_pair_i2c_slave
  import i2cCmdPkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR = 7'h2A,
  parameter int                FILT_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [BYTE_W-1:0] statusIn,
  output logic              sdaPullDn,
  output logic [BYTE_W-1:0] cmdA,
  output logic [BYTE_W-1:0] cmdB,
  output logic              commitPulse
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] rawLines, cleanLines;
  logic               sclFilt, sdaFilt;
  dpStrobes_t         strb;
  logic [BYTE_W-1:0]  rxByte;
  logic               txMsb, ackDrv, txDrv, startDet, stopDet;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < N_LINES; g++) begin : g_filt
    i2cGlitchFilter #(.STABLE_CNT(FILT_LEN)) filt_i (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end

  assign sclFilt = cleanLines[0];
  assign sdaFilt = cleanLines[1];

  i2cCmdCtl #(.DEV_ADDR(DEV_ADDR)) ctl_i (
    .clk(clk), .rstN(rstN), .sclF(sclFilt), .sdaF(sdaFilt), .rxByte(rxByte),
    .strb(strb), .ackDrv(ackDrv), .txDrv(txDrv),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2cCmdData data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaBit(sdaFilt), .statusByte(statusIn),
    .rxByte(rxByte), .txMsb(txMsb), .cmdA(cmdA), .cmdB(cmdB),
    .commitPulse(commitPulse)
  );

  assign sdaPullDn = ackDrv | (txDrv & ~txMsb);
endmodule

// File: rtl/cmd_pair_i2c_checker.sv
module cmdPairI2cChecker (
  input logic       clk,
  input logic       rstN,
  input logic       sclFilt,
  input logic       startDet,
  input logic       stopDet,
  input logic       ackDrv,
  input logic       txDrv,
  input logic       sdaPullDn,
  input logic [7:0] cmdA,
  input logic [7:0] cmdB,
  input logic       commitPulse
);
  p_cmd_moves_with_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdA != $past(cmdA) || cmdB != $past(cmdB)) |-> commitPulse);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |=> !commitPulse);

  p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(stopDet));

  p_release_after_stop_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(stopDet) |-> !sdaPullDn);

  p_single_driver_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(ackDrv && txDrv));

  p_drive_on_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDn != $past(sdaPullDn)) |-> (!sclFilt || $past(startDet || stopDet)));
endmodule

bind cmd_pair_i2c_slave cmdPairI2cChecker chk_i (
  .clk(clk), .rstN(rstN), .sclFilt(sclFilt), .startDet(startDet), .stopDet(stopDet),
  .ackDrv(ackDrv), .txDrv(txDrv), .sdaPullDn(sdaPullDn), .cmdA(cmdA), .cmdB(cmdB),
  .commitPulse(commitPulse)
);

// File: tb/cmd_pair_i2c_slave_tb.sv
module cmd_pair_i2c_slave_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          QTR        = 10;
  localparam logic [6:0]  DEV        = 7'h2A;
  localparam int          FILT       = 4;
  localparam int          WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic [7:0] statusIn = 8'h00;
  logic       sdaPullDn, commitPulse;
  logic [7:0] cmdA, cmdB;
  logic       sdaLine;

  int nChecks = 0, nFail = 0, commitCnt = 0, expCommits = 0, cycles = 0;
  logic [7:0] expA = 8'h00, expB = 8'h00;

  assign sdaLine = sdaM & ~sdaPullDn;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_pair_i2c_slave #(.DEV_ADDR(DEV), .FILT_LEN(FILT)) dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .statusIn(statusIn),
    .sdaPullDn(sdaPullDn), .cmdA(cmdA), .cmdB(cmdB), .commitPulse(commitPulse)
  );

  always @(posedge clk) if (rstN && commitPulse) commitCnt++;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expAck(input bit addrOk, input int idx);
    return addrOk && (idx < 2);
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitCyc(QTR);
    sclM = 1'b1; waitCyc(QTR);
    sdaM = 1'b0; waitCyc(QTR);
    sclM = 1'b0; waitCyc(QTR);
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitCyc(QTR);
    sclM = 1'b1; waitCyc(QTR);
    sdaM = 1'b1; waitCyc(2*QTR);
  endtask

  // glitch: short SDA low pulse while SCL high (on a 1 bit), short SCL high pulse while low
  task automatic writeBit(input logic b, input bit glitch);
    sdaM = b; waitCyc(QTR);
    sclM = 1'b1; waitCyc(QTR/2);
    if (glitch && b) begin
      sdaM = 1'b0; waitCyc(FILT-2); sdaM = 1'b1; waitCyc(QTR - QTR/2 - (FILT-2));
    end else waitCyc(QTR - QTR/2);
    sclM = 1'b0; waitCyc(QTR/2);
    if (glitch) begin
      sclM = 1'b1; waitCyc(FILT-2); sclM = 1'b0; waitCyc(QTR - QTR/2 - (FILT-2));
    end else waitCyc(QTR - QTR/2);
  endtask

  task automatic readBit(output logic b, output logic heldLow);
    sdaM = 1'b1; waitCyc(QTR);
    sclM = 1'b1; waitCyc(2);
    heldLow = 1'b1;
    for (int i = 0; i < 2*QTR - 4; i++) begin
      if (sdaLine) heldLow = 1'b0;
      if (i == QTR - 2) b = sdaLine;
      waitCyc(1);
    end
    waitCyc(2);
    sclM = 1'b0; waitCyc(QTR);
  endtask

  task automatic sendByte(input logic [7:0] v, input bit glitch, output logic acked);
    logic bit9, low9;
    for (int i = 7; i >= 0; i--) writeBit(v[i], glitch);
    readBit(bit9, low9);
    acked = low9;
  endtask

  task automatic recvByte(input bit masterAck, output logic [7:0] v, output logic pulled9);
    logic b, l;
    for (int i = 7; i >= 0; i--) begin
      readBit(b, l);
      v[i] = b;
    end
    sdaM = ~masterAck; waitCyc(QTR);
    sclM = 1'b1; waitCyc(QTR);
    pulled9 = sdaPullDn;
    waitCyc(QTR);
    sclM = 1'b0; waitCyc(QTR);
  endtask

  task automatic doWrite(input logic [6:0] addr, input int nBytes,
                         input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                         input bit glitch);
    logic ack;
    bit   addrOk;
    logic [7:0] bv;
    addrOk = (addr == DEV);
    startCond();
    sendByte({addr, 1'b0}, glitch, ack);
    check(addrOk ? "R2 addr ack" : "R7 foreign addr no ack", ack, addrOk);
    for (int i = 0; i < nBytes; i++) begin
      bv = (i == 0) ? b0 : (i == 1) ? b1 : b2;
      sendByte(bv, glitch, ack);
      check(i < 2 ? "R3 data ack" : "R5 extra byte nack", ack, expAck(addrOk, i));
    end
    if (addrOk && nBytes >= 2) begin
      check("R3 cmdA held before stop", cmdA, expA);
      check("R3 cmdB held before stop", cmdB, expB);
    end
    if (!addrOk) check("R7 no drive after foreign addr", sdaPullDn, 0);
    stopCond();
    waitCyc(4);
    if (addrOk && nBytes >= 2) begin
      expA = b0; expB = b1; expCommits++;
    end
    check((addrOk && nBytes >= 2) ? "R4 cmdA committed" : "R6 cmdA unchanged", cmdA, expA);
    check((addrOk && nBytes >= 2) ? "R4 cmdB committed" : "R6 cmdB unchanged", cmdB, expB);
    check("R4 commit pulse count", commitCnt, expCommits);
    check("R7 released after stop", sdaPullDn, 0);
  endtask

  task automatic doRead(input logic [7:0] st, input bit masterAck);
    logic ack, pulled9;
    logic [7:0] got;
    statusIn = st;
    startCond();
    sendByte({DEV, 1'b1}, 1'b0, ack);
    check("R8 read addr ack", ack, 1);
    recvByte(masterAck, got, pulled9);
    check("R8 status byte", got, st);
    check("R8 released in ninth clock", pulled9, 0);
    stopCond();
    waitCyc(4);
    check("R8 read no commit", commitCnt, expCommits);
    check("R8 cmdA untouched by read", cmdA, expA);
  endtask

  task automatic repStart();
    sdaM = 1'b1; waitCyc(QTR);
    sclM = 1'b1; waitCyc(QTR);
    sdaM = 1'b0; waitCyc(QTR);
    sclM = 1'b0; waitCyc(QTR);
  endtask

  initial begin
    logic ack;
    void'($urandom(32'd4711));
    waitCyc(5);
    check("R1 cmdA reset", cmdA, 0);
    check("R1 cmdB reset", cmdB, 0);
    check("R1 pull released", sdaPullDn, 0);
    check("R1 no pulse", commitPulse, 0);
    rstN = 1'b1;
    waitCyc(10);

    doWrite(DEV, 2, 8'hA5, 8'h3C, 8'h00, 1'b0);        // R2 R3 R4
    doWrite(DEV, 3, 8'h81, 8'h7E, 8'hFF, 1'b0);        // R5
    doWrite(DEV, 1, 8'h11, 8'h00, 8'h00, 1'b0);        // R6
    doWrite(DEV, 0, 8'h00, 8'h00, 8'h00, 1'b0);        // R6
    doWrite(DEV ^ 7'h01, 2, 8'h55, 8'h66, 8'h00, 1'b0); // R7
    doRead(8'hC3, 1'b0);                                // R8 master NACK
    doRead(8'h5A, 1'b1);                                // R8 master ACK
    doWrite(DEV, 2, 8'hFF, 8'hFE, 8'h00, 1'b1);        // R10 with glitches

    // R9: repeated start replaces an unfinished write
    startCond();
    sendByte({DEV, 1'b0}, 1'b0, ack);
    sendByte(8'h99, 1'b0, ack);
    repStart();
    sendByte({DEV, 1'b0}, 1'b0, ack);
    check("R9 addr ack after repeated start", ack, 1);
    sendByte(8'h12, 1'b0, ack);
    sendByte(8'h34, 1'b0, ack);
    stopCond(); waitCyc(4);
    expA = 8'h12; expB = 8'h34; expCommits++;
    check("R9 cmdA from restarted write", cmdA, expA);
    check("R9 cmdB from restarted write", cmdB, expB);

    // R9: full write abandoned by repeated start into a read
    startCond();
    sendByte({DEV, 1'b0}, 1'b0, ack);
    sendByte(8'hDE, 1'b0, ack);
    sendByte(8'hAD, 1'b0, ack);
    repStart();
    sendByte({DEV, 1'b1}, 1'b0, ack);
    begin
      logic [7:0] got; logic p9;
      recvByte(1'b0, got, p9);
    end
    stopCond(); waitCyc(4);
    check("R9 abandoned write not committed", cmdA, expA);
    check("R9 abandoned commit count", commitCnt, expCommits);

    for (int t = 0; t < 24; t++) begin
      int kind;
      kind = $urandom % 4;
      case (kind)
        0: doWrite(DEV, 2, 8'($urandom), 8'($urandom), 8'h00, 1'b0);
        1: doWrite(DEV, $urandom % 4, 8'($urandom), 8'($urandom), 8'($urandom), 1'b0);
        2: doRead(8'($urandom), 1'($urandom));
        default: doWrite(7'($urandom) | 7'h40, 2, 8'($urandom), 8'($urandom), 8'h00, 1'b0);
      endcase
    end
    summary();
  end
endmodule